// File: doc/BRIEF.md
# Stack Pointer Offset Tracker

This block sits in the in-order issue stage and accepts one decoded instruction per cycle on a valid/ready stream. It absorbs the implicit stack-pointer adjustment of push, pop, call and return. It does this by keeping a signed running displacement from the last architecturally synchronised stack pointer. Each stack access therefore becomes a single memory uop, addressed as the base register plus an offset, with no separate arithmetic uop.

When the displacement would leave its signed range, the tracker emits a synchronising "add stack pointer, immediate" uop that carries the accumulated displacement, and then clears it. It does the same when an instruction names the stack pointer explicitly. While a synchronising uop is emitted, the input stream is stalled for one cycle. The triggering instruction then issues on the following cycle, so uops always leave in program order.

Top module: `stk_offset_tracker`

## Requirements
- R1: A synchronous reset clears the displacement to zero. While `in_valid` is low, `out_valid` is low.
- R2: A push (op code 1) or call (op code 3) leaves as one store uop (kind 1) with offset equal to the displacement minus 8. It then lowers the displacement by 8.
- R3: A pop (op code 2) or return (op code 4) leaves as one load uop (kind 2) with offset equal to the current displacement. It then raises the displacement by 8.
- R4: When the displacement after the pending step of 8 would fall outside -128..+127, a sync uop is emitted first. The instruction is then handled against a displacement of zero.
- R5: An instruction that names the stack pointer explicitly (op code 5) is preceded by a sync uop when the displacement is nonzero, and by none when it is zero. It then leaves as a pass uop (kind 0) with offset 0.
- R6: A sync uop has kind 3, op field 0, data 0 and offset equal to the displacement held at that moment. After it is accepted, the displacement is zero.
- R7: In the cycle a sync uop is presented, `in_ready` is low. The triggering instruction is the next uop out, so output order matches input order.
- R8: Any other instruction (op code 0) leaves as a pass uop with its op and data unchanged and offset 0. The displacement is left unchanged.
- R9: While `out_ready` is low, `in_ready` is low and the displacement is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_op | input | 3 | Instruction class code |
| in_data | input | PAY_W | Opaque instruction payload |
| out_valid | output | 1 | Uop present |
| out_ready | input | 1 | Downstream accepts the uop |
| out_kind | output | 2 | Uop kind: pass, store, load, sync |
| out_op | output | 3 | Instruction class carried with the uop |
| out_off | output | DISP_W | Signed address offset, or sync immediate |
| out_data | output | PAY_W | Payload carried with the uop |

## Verification
The bench builds the tracker with an 8-bit displacement, a step of 8 and an 8-bit payload. With these values, sixteen pushes reach the negative limit and fifteen pops reach the last positive value. Both overflow edges, and the sync uop that carries -128 or +120, are therefore reached within a few dozen cycles. The payload width only sets how much the pass-through path can be seen to preserve.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OP_W   = 3;
  localparam int KIND_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_PLAIN = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_SPREF = 3'd5
  } op_e;

  typedef enum logic [KIND_W-1:0] {
    UK_PASS  = 2'd0,
    UK_STORE = 2'd1,
    UK_LOAD  = 2'd2,
    UK_SYNC  = 2'd3
  } kind_e;

  function automatic logic op_goes_down(logic [OP_W-1:0] op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

  function automatic logic op_goes_up(logic [OP_W-1:0] op);
    return (op == OP_POP) || (op == OP_RET);
  endfunction

  function automatic logic op_names_sp(logic [OP_W-1:0] op);
    return op == OP_SPREF;
  endfunction
endpackage

// File: rtl/stk_disp_step.sv
module stk_disp_step #(
  parameter int W    = 8,
  parameter int STEP = 8
) (
  input  logic [W-1:0] disp_i,
  input  logic         dn_i,
  input  logic         up_i,
  output logic [W-1:0] next_o,
  output logic [W-1:0] addr_o,
  output logic         oor_o
);
  localparam int XW = W + 1;
  localparam logic [XW-1:0] STEP_X = XW'(STEP);

  function automatic logic [XW-1:0] widen(logic [W-1:0] v);
    return {v[W-1], v};
  endfunction

  // a widened value fits in W signed bits when its two top bits agree
  function automatic logic fits(logic [XW-1:0] v);
    return v[XW-1] == v[XW-2];
  endfunction

  logic [XW-1:0] dn_x;
  logic [XW-1:0] up_x;

  always_comb begin
    dn_x = widen(disp_i) - STEP_X;
    up_x = widen(disp_i) + STEP_X;
    if (dn_i) begin
      next_o = dn_x[W-1:0];
      addr_o = dn_x[W-1:0];
      oor_o  = !fits(dn_x);
    end else if (up_i) begin
      next_o = up_x[W-1:0];
      addr_o = disp_i;
      oor_o  = !fits(up_x);
    end else begin
      next_o = disp_i;
      addr_o = '0;
      oor_o  = 1'b0;
    end
  end
endmodule

// File: rtl/stk_uop_build.sv
module stk_uop_build
  import stk_pkg::*;
#(
  parameter int W     = 8,
  parameter int PAY_W = 16
) (
  input  logic              sync_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [PAY_W-1:0]  data_i,
  input  logic              dn_i,
  input  logic              up_i,
  input  logic [W-1:0]      disp_i,
  input  logic [W-1:0]      addr_i,
  output logic [KIND_W-1:0] kind_o,
  output logic [OP_W-1:0]   op_o,
  output logic [W-1:0]      off_o,
  output logic [PAY_W-1:0]  data_o
);
  always_comb begin
    if (sync_i) begin
      kind_o = UK_SYNC;
      op_o   = OP_PLAIN;
      off_o  = disp_i;
      data_o = '0;
    end else begin
      op_o   = op_i;
      data_o = data_i;
      off_o  = addr_i;
      if (dn_i)      kind_o = UK_STORE;
      else if (up_i) kind_o = UK_LOAD;
      else           kind_o = UK_PASS;
    end
  end
endmodule

// File: rtl/stk_offset_tracker.sv
module stk_offset_tracker
  import stk_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int STEP   = 8,
  parameter int PAY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [PAY_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [2:0]        out_op,
  output logic [DISP_W-1:0] out_off,
  output logic [PAY_W-1:0]  out_data
);
  localparam logic [DISP_W-1:0] STEP_V = DISP_W'(STEP);

  logic [DISP_W-1:0] disp_q;
  logic [DISP_W-1:0] disp_moved;
  logic [DISP_W-1:0] addr_off;
  logic              step_oor;
  logic              is_down, is_up, is_spref, is_plain;
  logic              need_sync, sync_fire, instr_fire;

  assign is_down  = op_goes_down(in_op);
  assign is_up    = op_goes_up(in_op);
  assign is_spref = op_names_sp(in_op);
  assign is_plain = !(is_down || is_up || is_spref);

  stk_disp_step #(.W(DISP_W), .STEP(STEP)) step_i (
    .disp_i (disp_q),
    .dn_i   (is_down),
    .up_i   (is_up),
    .next_o (disp_moved),
    .addr_o (addr_off),
    .oor_o  (step_oor)
  );

  assign need_sync  = in_valid && (is_spref ? (disp_q != '0) : step_oor);
  assign in_ready   = out_ready && !need_sync;
  assign out_valid  = in_valid;
  assign sync_fire  = need_sync && out_ready;
  assign instr_fire = in_valid && in_ready;

  stk_uop_build #(.W(DISP_W), .PAY_W(PAY_W)) build_i (
    .sync_i (need_sync),
    .op_i   (in_op),
    .data_i (in_data),
    .dn_i   (is_down),
    .up_i   (is_up),
    .disp_i (disp_q),
    .addr_i (addr_off),
    .kind_o (out_kind),
    .op_o   (out_op),
    .off_o  (out_off),
    .data_o (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                              disp_q <= '0;
    else if (sync_fire)                   disp_q <= '0;
    else if (instr_fire && (is_down || is_up)) disp_q <= disp_moved;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> disp_q == '0); // R1
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (instr_fire && is_down) |=> disp_q == $past(disp_q) - STEP_V); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (instr_fire && is_up) |=> disp_q == $past(disp_q) + STEP_V); // R3
  AST_SYNC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    need_sync |-> disp_q != '0); // R5
  AST_SYNC_ZEROES: assert property (@(posedge clk) disable iff (rst)
    sync_fire |=> disp_q == '0); // R6
  AST_SYNC_STALLS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == UK_SYNC) |-> !in_ready); // R7
  AST_PLAIN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (instr_fire && is_plain) |=> $stable(disp_q)); // R8
  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_ready) |=> $stable(disp_q)); // R9
endmodule

// File: tb/stk_offset_tracker_tb.sv
module stk_offset_tracker_tb_top;
  localparam int DW = 8;
  localparam int PW = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = 3'd0;
  logic [PW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_kind;
  logic [2:0]    out_op;
  logic [DW-1:0] out_off;
  logic [PW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stk_offset_tracker #(.DISP_W(DW), .STEP(8), .PAY_W(PW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_op(out_op),
    .out_off(out_off), .out_data(out_data)
  );

  // {op, data, sync_expected, sync_off, kind, off}
  localparam logic [29:0] VEC [NV] = '{
    {3'd0, 8'h11, 1'b0, 8'h00, 2'd0, 8'h00},
    {3'd1, 8'h21, 1'b0, 8'h00, 2'd1, 8'hF8},
    {3'd3, 8'h22, 1'b0, 8'h00, 2'd1, 8'hF0},
    {3'd0, 8'h23, 1'b0, 8'h00, 2'd0, 8'h00},
    {3'd2, 8'h24, 1'b0, 8'h00, 2'd2, 8'hF0},
    {3'd5, 8'h25, 1'b1, 8'hF8, 2'd0, 8'h00},
    {3'd5, 8'h26, 1'b0, 8'h00, 2'd0, 8'h00},
    {3'd4, 8'h27, 1'b0, 8'h00, 2'd2, 8'h00},
    {3'd2, 8'h28, 1'b0, 8'h00, 2'd2, 8'h08},
    {3'd1, 8'h29, 1'b0, 8'h00, 2'd1, 8'h08},
    {3'd5, 8'h2A, 1'b1, 8'h08, 2'd0, 8'h00},
    {3'd1, 8'h2B, 1'b0, 8'h00, 2'd1, 8'hF8}
  };

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd1, 3'd3: return "R2";
      3'd2, 3'd4: return "R3";
      3'd5:       return "R5";
      default:    return "R8";
    endcase
  endfunction

  // present one instruction; sample just after the falling edge
  task automatic send(logic [2:0] op, logic [7:0] data, logic sy, logic [7:0] soff,
                      logic [1:0] kind, logic [7:0] off, string req);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = data;
    #1;
    if (sy) begin
      check("R6", "sync kind", 32'(out_kind), 32'd3);
      check("R6", "sync offset", 32'(out_off), 32'(soff));
      check("R7", "ready low during sync", 32'(in_ready), 32'd0);
      @(negedge clk); #1;
    end
    check(req, "valid", 32'(out_valid), 32'd1);
    check(req, "ready", 32'(in_ready), 32'd1);
    check(req, "kind", 32'(out_kind), 32'(kind));
    check(req, "offset", 32'(out_off), 32'(off));
    check(req, "op", 32'(out_op), 32'(op));
    check(req, "data", 32'(out_data), 32'(data));
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "idle out_valid", 32'(out_valid), 32'd0);

    // table walk (R2 R3 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][29:27], VEC[i][26:19], VEC[i][18], VEC[i][17:10],
           VEC[i][9:8], VEC[i][7:0], req_of(VEC[i][29:27]));
    end
    go_idle();

    // R4 negative edge: 16 pushes reach -128, the 17th needs a sync
    do_reset();
    for (int k = 1; k <= 16; k++) send(3'd1, 8'(k), 1'b0, 8'h00, 2'd1, 8'(-8 * k), "R2");
    send(3'd1, 8'h77, 1'b1, 8'h80, 2'd1, 8'hF8, "R4");
    go_idle();

    // R4 positive edge: 15 pops reach +120, the 16th needs a sync
    do_reset();
    for (int k = 0; k < 15; k++) send(3'd2, 8'(k), 1'b0, 8'h00, 2'd2, 8'(8 * k), "R3");
    send(3'd4, 8'h66, 1'b1, 8'h78, 2'd2, 8'h00, "R4");
    go_idle();

    // R9: back-pressure holds the displacement (currently +8)
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 3'd1; in_data = 8'h55;
    #1;
    check("R9", "ready under back-pressure", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R9", "held push offset", 32'(out_off), 32'h00);
    @(negedge clk);
    in_op = 3'd2; in_data = 8'h56;
    #1;
    check("R9", "pop after one push", 32'(out_off), 32'h00);
    go_idle();

    // R1: reset mid-stream clears the displacement
    send(3'd1, 8'h01, 1'b0, 8'h00, 2'd1, 8'h00, "R2");
    do_reset();
    #1;
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    send(3'd2, 8'h02, 1'b0, 8'h00, 2'd2, 8'h00, "R1");
    go_idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule